// File: doc/BRIEF.md
# X-ray Protection Latch Controller

This block decides how a display controller reacts when its X-ray fault detector trips. The fault line arrives with no timing relation to the system clock. It is brought into the clock domain by a two-stage synchroniser and then cleaned by a three-sample majority vote. A rising edge of the cleaned level records a fault event in a sticky status flag. Once the block has requested idle (drive off), that request stays in force until reset.

One configuration bit selects how the block responds. With the bit clear, the block is autonomous: a fault requests idle on the same clock edge that records the event. With the bit set, the block is supervised. An interrupt tells the microcontroller about the event, and the microcontroller takes over by clearing the sticky flag. A programmable watchdog window starts when the event is recorded. If the window runs out while the flag is still set, the block requests idle anyway.

Software reaches the block through a small word-wide register port with a combinational read path. That port gives access to the mode bit, the window length and a status word. The status word carries the sticky event flag, the live synchronised fault level and the idle flag.

Top module: `xprot_ctrl`

## Requirements
- R1: After reset, idle_o and irq_o are 0 and the mode bit reads 0 (autonomous). The window register reads its reset value of 1000, and the status word reads 0 while the fault pin is low.
- R2: A fault pulse that lasts a single clock is filtered out and records no event. A pulse of two or more clocks sets the event flag (status bit 2) five rising clock edges after the pin is first sampled high.
- R3: Status bit 1 shows the synchronised, unlatched fault level. It follows the pin after two rising edges and falls again when the pin falls.
- R4: In autonomous mode (control register at address 0, bit 2 = 0), idle_o rises on the same edge that sets the event flag.
- R5: The event flag stays set after the pin falls. Writing a word with bit 2 = 1 to the status register (address 2) leaves the flag set, and writing a word with bit 2 = 0 clears it.
- R6: A status write with bit 2 = 0 that coincides with a new filtered rising edge does not clear the flag: the flag reads 1 afterwards.
- R7: irq_o is 1 exactly while the event flag is set and the mode bit is 1.
- R8: In supervised mode the window register (address 1, 16 bits) holds W. If the flag is not cleared, idle_o rises W+1 edges after the edge that set the flag, and not before.
- R9: In supervised mode, clearing the flag on edge E+d, where E is the edge that set the flag and 1 ≤ d ≤ W, keeps idle_o low. A clear on edge E+W+1 or later comes too late.
- R10: Once idle_o is 1 it stays 1 until reset, whatever the register writes or pin activity.
- R11: The window register reads back all 16 bits as written. The control register reads back only bit 2, with the other bits reading 0, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xray_pin_i | input | 1 | Asynchronous fault level from the X-ray detector |
| reg_we_i | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr_i | input | 2 | Register address: 0 control, 1 window, 2 status |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Combinational read data for reg_addr_i |
| irq_o | output | 1 | Interrupt to the microcontroller in supervised mode |
| idle_o | output | 1 | Latched request to force the system idle |

## Verification
A stuck or lost event flag shows at the status read port and at irq_o within one clock of the edge that should have changed it. A wrong filter or synchroniser depth moves the five-edge event latency or lets a one-clock glitch through, and this is visible in the first read after the pulse. A window counter that reloads, stalls or is off by one moves the idle_o rise by at least one edge from W+1. A counter that keeps running after acknowledge raises idle_o within W+1 edges of the event where it should stay low. Randomised window lengths and acknowledge delays, together with the directed boundaries d = W and d = W+1, make either fault visible on idle_o within the trial where it occurs.

// File: rtl/xprot_pkg.sv
package xprot_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL = 2'd0,
        ADR_WIN  = 2'd1,
        ADR_STAT = 2'd2,
        ADR_NONE = 2'd3
    } reg_addr_e;

    localparam int CTRL_SUP_BIT  = 2;
    localparam int STAT_EVT_BIT  = 2;
    localparam int STAT_LIVE_BIT = 1;
    localparam int STAT_IDLE_BIT = 0;

    typedef struct packed {
        logic evt;
        logic live;
        logic idle;
    } stat_t;

    function automatic logic [REG_W-1:0] pack_status(stat_t s);
        logic [REG_W-1:0] r;
        r                = '0;
        r[STAT_EVT_BIT]  = s.evt;
        r[STAT_LIVE_BIT] = s.live;
        r[STAT_IDLE_BIT] = s.idle;
        return r;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(logic sup);
        logic [REG_W-1:0] r;
        r               = '0;
        r[CTRL_SUP_BIT] = sup;
        return r;
    endfunction

endpackage

// File: rtl/xprot_sync_filter.sv
module xprot_sync_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_TAPS   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic live,
    output logic rise
);
    localparam int MAJ_LIMIT = FILT_TAPS / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_TAPS-1:0]   tap_q;
    logic                   filt;
    logic                   filt_d;

    generate
        genvar gi;
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_q[gi] <= 1'b0;
                end else if (gi == 0) begin
                    sync_q[gi] <= pin_async;
                end else begin
                    sync_q[gi] <= sync_q[(gi == 0) ? 0 : gi-1];
                end
            end
        end
        for (gi = 0; gi < FILT_TAPS; gi++) begin : g_tap
            always_ff @(posedge clk) begin
                if (rst) begin
                    tap_q[gi] <= 1'b0;
                end else if (gi == 0) begin
                    tap_q[gi] <= sync_q[SYNC_STAGES-1];
                end else begin
                    tap_q[gi] <= tap_q[(gi == 0) ? 0 : gi-1];
                end
            end
        end
    endgenerate

    assign live = sync_q[SYNC_STAGES-1];
    assign filt = ($countones(tap_q) > MAJ_LIMIT);

    always_ff @(posedge clk) begin
        if (rst) filt_d <= 1'b0;
        else     filt_d <= filt;
    end

    assign rise = filt & ~filt_d;

    // R2: an edge needs a majority of taps high
    a_r2_rise_has_majority: assert property (@(posedge clk) disable iff (rst)
        rise |-> ($countones(tap_q) >= MAJ_LIMIT + 1));

endmodule

// File: rtl/xprot_regs.sv
module xprot_regs
    import xprot_pkg::*;
#(
    parameter int               WIN_W   = 16,
    parameter logic [WIN_W-1:0] WIN_RST = WIN_W'(1000)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              evt_rise,
    input  logic              live,
    input  logic              idle,
    output logic [REG_W-1:0]  rdata,
    output logic              sup_en,
    output logic [WIN_W-1:0]  win_val,
    output logic              evt,
    output logic              evt_clr
);
    logic             sup_q;
    logic [WIN_W-1:0] win_q;
    logic             evt_q;
    logic             wr_ctrl;
    logic             wr_win;
    logic             wr_stat0;
    stat_t            stat;

    assign wr_ctrl  = we && (reg_addr_e'(addr) == ADR_CTRL);
    assign wr_win   = we && (reg_addr_e'(addr) == ADR_WIN);
    assign wr_stat0 = we && (reg_addr_e'(addr) == ADR_STAT) && !wdata[STAT_EVT_BIT];
    assign evt_clr  = wr_stat0 && evt_q && !evt_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            sup_q <= 1'b0;
            win_q <= WIN_RST;
            evt_q <= 1'b0;
        end else begin
            if (wr_ctrl) sup_q <= wdata[CTRL_SUP_BIT];
            if (wr_win)  win_q <= wdata[WIN_W-1:0];
            if (evt_rise)     evt_q <= 1'b1;
            else if (evt_clr) evt_q <= 1'b0;
        end
    end

    always_comb begin
        stat.evt  = evt_q;
        stat.live = live;
        stat.idle = idle;
        rdata     = '0;
        case (reg_addr_e'(addr))
            ADR_CTRL: rdata = pack_ctrl(sup_q);
            ADR_WIN:  rdata[WIN_W-1:0] = win_q;
            ADR_STAT: rdata = pack_status(stat);
            default:  rdata = '0;
        endcase
    end

    assign sup_en  = sup_q;
    assign win_val = win_q;
    assign evt     = evt_q;

    // R5: flag holds unless a clearing write arrives
    a_r5_evt_sticky: assert property (@(posedge clk) disable iff (rst)
        (evt_q && !wr_stat0) |=> evt_q);
    // R6: a new edge always leaves the flag set
    a_r6_edge_wins: assert property (@(posedge clk) disable iff (rst)
        evt_rise |=> evt_q);

endmodule

// File: rtl/xprot_timer.sv
module xprot_timer #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sup_en,
    input  logic             evt_rise,
    input  logic             evt_clr,
    input  logic [WIN_W-1:0] win_val,
    output logic             idle
);
    logic             run_q;
    logic [WIN_W-1:0] cnt_q;
    logic             idle_q;
    logic             force_auto;
    logic             expire;

    assign force_auto = evt_rise && !sup_en;
    assign expire     = run_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            idle_q <= 1'b0;
        end else begin
            if (force_auto || expire) idle_q <= 1'b1;
            if (evt_rise && sup_en) begin
                run_q <= 1'b1;
                cnt_q <= win_val;
            end else if (evt_clr) begin
                run_q <= 1'b0;
            end else if (run_q && (cnt_q != '0)) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign idle = idle_q;

    // R4: autonomous fault requests idle on the next edge
    a_r4_auto_idle: assert property (@(posedge clk) disable iff (rst)
        (evt_rise && !sup_en) |=> idle_q);
    // R8: window countdown advances by one per clock
    a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
        (run_q && (cnt_q != '0) && !evt_rise && !evt_clr) |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R8: exhausted window requests idle
    a_r8_expire_idle: assert property (@(posedge clk) disable iff (rst)
        expire |=> idle_q);
    // R9: acknowledge stops the window
    a_r9_ack_stops: assert property (@(posedge clk) disable iff (rst)
        evt_clr |=> !run_q);
    // R10: idle request is latched
    a_r10_idle_latched: assert property (@(posedge clk) disable iff (rst)
        idle_q |=> idle_q);

endmodule

// File: rtl/xprot_ctrl.sv
module xprot_ctrl
    import xprot_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_TAPS   = 3,
    parameter int WIN_W       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xray_pin_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_o,
    output logic              idle_o
);
    logic             live;
    logic             rise;
    logic             sup_en;
    logic [WIN_W-1:0] win_val;
    logic             evt;
    logic             evt_clr;
    logic             idle;

    xprot_sync_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_TAPS  (FILT_TAPS)
    ) u_filt (
        .clk      (clk),
        .rst      (rst),
        .pin_async(xray_pin_i),
        .live     (live),
        .rise     (rise)
    );

    xprot_regs #(
        .WIN_W(WIN_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we_i),
        .addr    (reg_addr_i),
        .wdata   (reg_wdata_i),
        .evt_rise(rise),
        .live    (live),
        .idle    (idle),
        .rdata   (reg_rdata_o),
        .sup_en  (sup_en),
        .win_val (win_val),
        .evt     (evt),
        .evt_clr (evt_clr)
    );

    xprot_timer #(
        .WIN_W(WIN_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .sup_en  (sup_en),
        .evt_rise(rise),
        .evt_clr (evt_clr),
        .win_val (win_val),
        .idle    (idle)
    );

    assign irq_o  = evt && sup_en;
    assign idle_o = idle;

    // R7: interrupt only accompanies a recorded event
    a_r7_irq_needs_evt: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> evt);

endmodule

// File: tb/tb_xprot_ctrl.sv
`timescale 1ns/1ps
module tb_xprot_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xray_pin_i = 1'b0;
    logic        reg_we_i = 1'b0;
    logic [1:0]  reg_addr_i = 2'd0;
    logic [15:0] reg_wdata_i = 16'd0;
    logic [15:0] reg_rdata_o;
    logic        irq_o;
    logic        idle_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    xprot_ctrl dut (
        .clk        (clk),
        .rst        (rst),
        .xray_pin_i (xray_pin_i),
        .reg_we_i   (reg_we_i),
        .reg_addr_i (reg_addr_i),
        .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o),
        .irq_o      (irq_o),
        .idle_o     (idle_o)
    );

    function automatic bit exp_idle(int w, int d);
        return (d < 0) || (d > w);
    endfunction

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] v);
        reg_addr_i = a;
        #1;
        v = reg_rdata_o;
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_we_i = 1'b0;
    endtask

    task automatic do_reset();
        xray_pin_i = 1'b0;
        reg_we_i = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        step(3);
        rst = 1'b0;
    endtask

    task automatic sup_trial(int w, int d);
        logic [15:0] v;
        do_reset();
        wr(2'd0, 16'h0004);
        wr(2'd1, 16'(w));
        @(negedge clk);
        xray_pin_i = 1'b1;
        if (d < 0) begin
            step(5 + w);
            check("R8 idle low before window end", {15'd0, idle_o}, 16'd0);
            check("R7 irq while event pending", {15'd0, irq_o}, 16'd1);
            step(1);
            check("R8 idle at window end", {15'd0, idle_o}, 16'd1);
        end else begin
            step(4 + d);
            reg_we_i = 1'b1; reg_addr_i = 2'd2; reg_wdata_i = 16'h0000;
            step(1);
            reg_we_i = 1'b0;
            rd(2'd2, v);
            check("R9 event cleared by ack", {15'd0, v[2]}, 16'd0);
            check("R7 irq low after ack", {15'd0, irq_o}, 16'd0);
            step(w + 10);
            check("R9 idle after ack", {15'd0, idle_o}, {15'd0, exp_idle(w, d)});
        end
        xray_pin_i = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'h5EED_0107));

        // R1 reset state
        do_reset();
        check("R1 idle", {15'd0, idle_o}, 16'd0);
        check("R1 irq", {15'd0, irq_o}, 16'd0);
        rd(2'd0, v); check("R1 ctrl", v, 16'h0000);
        rd(2'd1, v); check("R1 window", v, 16'd1000);
        rd(2'd2, v); check("R1 status", v, 16'h0000);

        // R11 register readback
        wr(2'd1, 16'hA5C3);
        rd(2'd1, v); check("R11 window readback", v, 16'hA5C3);
        wr(2'd0, 16'hFFFF);
        rd(2'd0, v); check("R11 ctrl only bit 2", v, 16'h0004);
        wr(2'd0, 16'hFFFB);
        rd(2'd0, v); check("R11 ctrl cleared", v, 16'h0000);
        rd(2'd3, v); check("R11 unmapped reads 0", v, 16'h0000);

        // R3 live level, R2 latency, R4 autonomous idle
        do_reset();
        @(negedge clk);
        xray_pin_i = 1'b1;
        step(1);
        rd(2'd2, v); check("R3 live not yet", {15'd0, v[1]}, 16'd0);
        step(1);
        rd(2'd2, v); check("R3 live after two edges", {15'd0, v[1]}, 16'd1);
        step(2);
        rd(2'd2, v); check("R2 event not before fifth edge", {15'd0, v[2]}, 16'd0);
        check("R4 idle not early", {15'd0, idle_o}, 16'd0);
        step(1);
        rd(2'd2, v); check("R2 event at fifth edge", {15'd0, v[2]}, 16'd1);
        check("R4 autonomous idle", {15'd0, idle_o}, 16'd1);
        check("R7 no irq in autonomous mode", {15'd0, irq_o}, 16'd0);
        xray_pin_i = 1'b0;
        step(10);
        rd(2'd2, v); check("R3 live falls", {15'd0, v[1]}, 16'd0);
        check("R5 event sticky after pin low", {15'd0, v[2]}, 16'd1);
        wr(2'd2, 16'h0004);
        rd(2'd2, v); check("R5 write of 1 ignored", {15'd0, v[2]}, 16'd1);
        wr(2'd2, 16'h0000);
        rd(2'd2, v); check("R5 write of 0 clears", {15'd0, v[2]}, 16'd0);
        check("R10 idle stays after clear", {15'd0, idle_o}, 16'd1);
        @(negedge clk); xray_pin_i = 1'b1;
        step(8); xray_pin_i = 1'b0;
        wr(2'd0, 16'h0004);
        step(4);
        check("R10 idle stays after activity", {15'd0, idle_o}, 16'd1);

        // R2 glitch filtering
        do_reset();
        @(negedge clk); xray_pin_i = 1'b1;
        step(1); xray_pin_i = 1'b0;
        step(12);
        rd(2'd2, v); check("R2 one-clock glitch ignored", {15'd0, v[2]}, 16'd0);
        check("R2 glitch no idle", {15'd0, idle_o}, 16'd0);
        xray_pin_i = 1'b1;
        step(2); xray_pin_i = 1'b0;
        step(3);
        rd(2'd2, v); check("R2 two-clock pulse detected", {15'd0, v[2]}, 16'd1);

        // R6 collision of clear with edge, then ack keeps idle low
        do_reset();
        wr(2'd0, 16'h0004);
        wr(2'd1, 16'd100);
        @(negedge clk); xray_pin_i = 1'b1;
        step(4);
        reg_we_i = 1'b1; reg_addr_i = 2'd2; reg_wdata_i = 16'h0000;
        step(1);
        reg_we_i = 1'b0;
        rd(2'd2, v); check("R6 edge wins over clear", {15'd0, v[2]}, 16'd1);
        check("R7 irq in supervised mode", {15'd0, irq_o}, 16'd1);
        wr(2'd2, 16'h0000);
        check("R7 irq drops with flag", {15'd0, irq_o}, 16'd0);
        step(150);
        check("R9 acknowledged event no idle", {15'd0, idle_o}, 16'd0);
        xray_pin_i = 1'b0;

        // R8 / R9 directed boundaries
        sup_trial(0, -1);
        sup_trial(5, 5);
        sup_trial(5, 6);
        sup_trial(20, -1);
        sup_trial(3, 1);

        // R8 / R9 constrained random trials
        for (int i = 0; i < 24; i++) begin
            int w = int'($urandom_range(0, 30));
            int d = ($urandom_range(0, 3) == 0) ? -1 : int'($urandom_range(1, 40));
            sup_trial(w, d);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule